// File: doc/BRIEF.md
# Single-Line Bit-Serial Register Access Engine

This block is the host-facing front end of a slow peripheral that exchanges data one bit per bus access over a single data line. The host drives an active-low select together with active-low read and write pulses. The engine turns each completed access into a read or write bit event and assembles a 4-bit address, least significant bit first. That address either triggers one of two command pulses or opens an 8-bit data transfer against a byte-wide register port. The register contents behind the port are outside this block.

A parameter selects the pin convention. In bus mode a write bit is select plus write pulse, and a read bit is select plus read pulse. In three-wire mode the write-pulse pin acts as an active-low serial clock, and the read-pulse pin carries a direction level: low means write, high means read. All pins are brought into the system clock domain through synchronisers. No access is ever refused. Software can always regain alignment by issuing eight reads in a row.

Top module: `bitline_access_engine`

## Requirements
- R1: An address is formed by four consecutive write bits taken from `sdIn`. The first written bit is bit 0 and the fourth is bit 3. Once bit 3 is in, `regAddr` shows the nibble and holds it until the next address phase starts.
- R2: A read access while the engine waits for an address bit does not start a cycle. It also discards any address bits already collected, so the next write is again bit 0.
- R3: Address 0xE produces a one-cycle `cmdSet` pulse and address 0xF a one-cycle `cmdGet` pulse, with `regAddr` equal to the code during the pulse. No data phase follows, and the next write is taken as address bit 0.
- R4: For any other address, if the first access after the address is a write, eight writes form a byte, bit 0 first. Exactly one single-cycle `regWrEn` pulse carries the byte on `regWrData` with the address on `regAddr`, and no pulse appears before the eighth bit.
- R5: For any other address, `regRdReq` pulses for one cycle after address bit 3 and the byte on `regRdData` is captured. If the next access is a read, eight reads present that byte on `sdOut`, bit 0 first, each bit valid from three clocks after its access begins.
- R6: A data cycle ends with its eighth bit, and the following write is taken as address bit 0.
- R7: Eight consecutive read accesses leave the engine waiting for address bit 0, from any state: partial address, partial write data or partial read data. No write strobe is issued for a cycle abandoned this way.
- R8: A read during a write-data phase, or a write during a read-data phase, drops the cycle without a `regWrEn`. The offending access is discarded and the engine waits for address bit 0.
- R9: A gap of any length between two bit accesses leaves the cycle state unchanged.
- R10: With `THREE_WIRE` set, each falling edge of `wrStrobeN` while `selN` is low is one bit access, read when `rdStrobeN` is high and write when it is low. R1 to R9 then hold unchanged.
- R11: After reset, `regWrEn`, `regRdReq`, `cmdSet`, `cmdGet`, `sdOut` and `regAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low chip select |
| rdStrobeN | input | 1 | Active-low read pulse (bus mode) or direction level (three-wire mode) |
| wrStrobeN | input | 1 | Active-low write pulse (bus mode) or active-low serial clock (three-wire mode) |
| sdIn | input | 1 | Serial data line, host to engine |
| sdOut | output | 1 | Serial data line, engine to host |
| regAddr | output | ADDR_W | Assembled address |
| regWrData | output | DATA_W | Byte for the register port |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdReq | output | 1 | One-cycle register fetch request |
| regRdData | input | DATA_W | Byte returned by the register port in the request cycle |
| cmdSet | output | 1 | One-cycle pulse for command code 0xE |
| cmdGet | output | 1 | One-cycle pulse for command code 0xF |

## Verification
A pin change reaches the event logic after two synchroniser flops and one edge-detect compare. The registered results therefore appear three clocks after the access begins: `regAddr`, the command and request pulses, `regWrEn`, and the `sdOut` bit. The bench holds each strobe for six clocks before it samples `sdOut`, and keeps five idle clocks after release. Pulses are counted on the falling clock edge, so each one is seen once. Counts and captured bytes are compared only after a whole access sequence has settled.

// File: rtl/sbit_pkg.sv
package sbit_pkg;
  // bit events seen by the control, one cycle wide
  typedef struct packed {
    logic rdEv;
    logic wrEv;
    logic bitIn;
  } sbit_evt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addrShift;
    logic fetch;
    logic cmdSet;
    logic cmdGet;
    logic dataShiftWr;
    logic commit;
    logic dataShiftRd;
  } sbit_ctl_t;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DIR   = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } sbit_phase_t;
endpackage

// File: rtl/sbit_datapath.sv
module sbit_datapath
  import sbit_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit THREE_WIRE  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  input  logic              sdIn,
  input  sbit_ctl_t         ctl,
  input  logic [DATA_W-1:0] regRdData,
  output sbit_evt_t         evt,
  output logic [ADDR_W-1:0] addrNibble,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdReq,
  output logic              cmdSet,
  output logic              cmdGet,
  output logic              sdOut
);
  localparam int PIN_N = 4;

  logic [PIN_N-1:0] syncQ [SYNC_STAGES];
  logic [PIN_N-1:0] pinS;
  logic [ADDR_W-1:0] addrSr;
  logic [DATA_W-1:0] dataSr;
  logic sdOutQ;
  logic rdEvRaw, wrEvRaw;

  // pin order: {data, write pulse, read pulse, select}
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '1;
    end else begin
      syncQ[0] <= {sdIn, wrStrobeN, rdStrobeN, selN};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end
  assign pinS = syncQ[SYNC_STAGES-1];

  generate
    if (THREE_WIRE) begin : g_three_wire
      logic clkPrev;
      logic clkAct;
      assign clkAct = ~pinS[0] & ~pinS[2];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) clkPrev <= 1'b0;
        else       clkPrev <= clkAct;
      end
      assign rdEvRaw = clkAct & ~clkPrev &  pinS[1];
      assign wrEvRaw = clkAct & ~clkPrev & ~pinS[1];
    end else begin : g_bus
      logic [1:0] actPrev;
      logic [1:0] actNow;
      logic [1:0] rise;
      assign actNow = {~pinS[0] & ~pinS[2], ~pinS[0] & ~pinS[1]};
      assign rise   = actNow & ~actPrev;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) actPrev <= 2'b00;
        else       actPrev <= actNow;
      end
      // simultaneous read and write starts are discarded
      assign rdEvRaw = rise[0] & ~rise[1];
      assign wrEvRaw = rise[1] & ~rise[0];
    end
  endgenerate

  assign evt.rdEv  = rdEvRaw;
  assign evt.wrEv  = wrEvRaw;
  assign evt.bitIn = pinS[3];
  assign addrNibble = {pinS[3], addrSr[ADDR_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSr    <= '0;
      dataSr    <= '0;
      sdOutQ    <= 1'b0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
      regRdReq  <= 1'b0;
      cmdSet    <= 1'b0;
      cmdGet    <= 1'b0;
    end else begin
      regWrEn  <= 1'b0;
      regRdReq <= ctl.fetch;
      cmdSet   <= ctl.cmdSet;
      cmdGet   <= ctl.cmdGet;
      if (ctl.addrShift) addrSr <= addrNibble;
      if (ctl.dataShiftWr) begin
        dataSr <= {pinS[3], dataSr[DATA_W-1:1]};
      end else if (ctl.dataShiftRd) begin
        sdOutQ <= dataSr[0];
        dataSr <= {1'b0, dataSr[DATA_W-1:1]};
      end else if (regRdReq) begin
        dataSr <= regRdData;
      end
      if (ctl.commit) begin
        regWrData <= {pinS[3], dataSr[DATA_W-1:1]};
        regWrEn   <= 1'b1;
      end
    end
  end

  assign regAddr = addrSr;
  assign sdOut   = sdOutQ;
endmodule

// File: rtl/sbit_control.sv
module sbit_control
  import sbit_pkg::*;
#(
  parameter int               ADDR_W  = 4,
  parameter int               DATA_W  = 8,
  parameter logic [ADDR_W-1:0] CMD_SET = 4'hE,
  parameter logic [ADDR_W-1:0] CMD_GET = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbit_evt_t         evt,
  input  logic [ADDR_W-1:0] addrNibble,
  output sbit_ctl_t         ctl
);
  localparam int MAX_BITS = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W    = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  sbit_phase_t phase;
  logic [CNT_W-1:0] cnt;
  logic addrDone, isCmd, dataLast;

  assign addrDone = (phase == PH_ADDR) && evt.wrEv && (cnt == ADDR_LAST);
  assign isCmd    = (addrNibble == CMD_SET) || (addrNibble == CMD_GET);
  assign dataLast = (cnt == DATA_LAST);

  always_comb begin
    ctl             = '0;
    ctl.addrShift   = (phase == PH_ADDR) && evt.wrEv;
    ctl.fetch       = addrDone && !isCmd;
    ctl.cmdSet      = addrDone && (addrNibble == CMD_SET);
    ctl.cmdGet      = addrDone && (addrNibble == CMD_GET);
    ctl.dataShiftWr = ((phase == PH_DIR) || (phase == PH_WRITE)) && evt.wrEv;
    ctl.commit      = (phase == PH_WRITE) && evt.wrEv && dataLast;
    ctl.dataShiftRd = ((phase == PH_DIR) || (phase == PH_READ)) && evt.rdEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_ADDR;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_ADDR: begin
          if (evt.rdEv) begin
            cnt <= '0;
          end else if (evt.wrEv) begin
            if (cnt == ADDR_LAST) begin
              cnt   <= '0;
              phase <= isCmd ? PH_ADDR : PH_DIR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_DIR: begin
          if (evt.wrEv) begin
            phase <= PH_WRITE;
            cnt   <= CNT_W'(1);
          end else if (evt.rdEv) begin
            phase <= PH_READ;
            cnt   <= CNT_W'(1);
          end
        end
        PH_WRITE: begin
          if (evt.rdEv || (evt.wrEv && dataLast)) begin
            phase <= PH_ADDR;
            cnt   <= '0;
          end else if (evt.wrEv) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_READ: begin
          if (evt.wrEv || (evt.rdEv && dataLast)) begin
            phase <= PH_ADDR;
            cnt   <= '0;
          end else if (evt.rdEv) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_ADDR;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitline_access_engine.sv
module bitline_access_engine
  import sbit_pkg::*;
#(
  parameter int               ADDR_W      = 4,
  parameter int               DATA_W      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter bit               THREE_WIRE  = 1'b0,
  parameter logic [ADDR_W-1:0] CMD_SET    = 4'hE,
  parameter logic [ADDR_W-1:0] CMD_GET    = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  input  logic              sdIn,
  output logic              sdOut,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdReq,
  input  logic [DATA_W-1:0] regRdData,
  output logic              cmdSet,
  output logic              cmdGet
);
  sbit_evt_t evt;
  sbit_ctl_t ctl;
  logic [ADDR_W-1:0] addrNibble;

  sbit_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES), .THREE_WIRE(THREE_WIRE)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .selN(selN), .rdStrobeN(rdStrobeN),
    .wrStrobeN(wrStrobeN), .sdIn(sdIn), .ctl(ctl), .regRdData(regRdData),
    .evt(evt), .addrNibble(addrNibble), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdReq(regRdReq),
    .cmdSet(cmdSet), .cmdGet(cmdGet), .sdOut(sdOut)
  );

  sbit_control #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_SET(CMD_SET), .CMD_GET(CMD_GET)
  ) control_i (
    .clk(clk), .rstN(rstN), .evt(evt), .addrNibble(addrNibble), .ctl(ctl)
  );
endmodule

// File: rtl/bitline_access_engine_chk.sv
module bitline_access_engine_chk #(
  parameter int               ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] CMD_SET = 4'hE,
  parameter logic [ADDR_W-1:0] CMD_GET = 4'hF
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              regRdReq,
  input logic              cmdSet,
  input logic              cmdGet
);
  // R4
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
  // R4
  wr_not_command_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regAddr != CMD_SET) && (regAddr != CMD_GET));
  // R5
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdReq |=> !regRdReq);
  // R5
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdReq |=> $stable(regAddr));
  // R3
  set_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdSet |-> regAddr == CMD_SET);
  // R3
  get_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdGet |-> regAddr == CMD_GET);
  // R3
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdSet, cmdGet, regRdReq, regWrEn}));
endmodule

bind bitline_access_engine bitline_access_engine_chk #(
  .ADDR_W(ADDR_W), .CMD_SET(CMD_SET), .CMD_GET(CMD_GET)
) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regRdReq(regRdReq), .cmdSet(cmdSet), .cmdGet(cmdGet)
);

// File: tb/bitline_access_engine_tb_top.sv
module bitline_access_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] selN = 2'b11, rdN = 2'b11, wrN = 2'b11, sdIn = 2'b00;
  logic [1:0] sdOut, wrEn, rdReq, cSet, cGet;
  logic [3:0] regAddr [2];
  logic [7:0] wrData [2];
  logic [7:0] rdData [2];

  int checks = 0, errors = 0;
  int wrCnt [2], rdCnt [2], setCnt [2], getCnt [2];
  logic [7:0] lastWr [2];
  logic [3:0] lastWrAddr [2];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [3:0] a);
    return 8'hA5 ^ (8'(a) * 8'd37);
  endfunction

  assign rdData[0] = pat(regAddr[0]);
  assign rdData[1] = pat(regAddr[1]);

  bitline_access_engine #(.THREE_WIRE(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .selN(selN[0]), .rdStrobeN(rdN[0]),
    .wrStrobeN(wrN[0]), .sdIn(sdIn[0]), .sdOut(sdOut[0]),
    .regAddr(regAddr[0]), .regWrData(wrData[0]), .regWrEn(wrEn[0]),
    .regRdReq(rdReq[0]), .regRdData(rdData[0]), .cmdSet(cSet[0]),
    .cmdGet(cGet[0]));

  bitline_access_engine #(.THREE_WIRE(1'b1)) dut3_i (
    .clk(clk), .rstN(rstN), .selN(selN[1]), .rdStrobeN(rdN[1]),
    .wrStrobeN(wrN[1]), .sdIn(sdIn[1]), .sdOut(sdOut[1]),
    .regAddr(regAddr[1]), .regWrData(wrData[1]), .regWrEn(wrEn[1]),
    .regRdReq(rdReq[1]), .regRdData(rdData[1]), .cmdSet(cSet[1]),
    .cmdGet(cGet[1]));

  initial begin
    for (int k = 0; k < 2; k++) begin
      wrCnt[k] = 0; rdCnt[k] = 0; setCnt[k] = 0; getCnt[k] = 0;
      lastWr[k] = '0; lastWrAddr[k] = '0;
    end
  end

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (wrEn[k]) begin
        wrCnt[k]++; lastWr[k] = wrData[k]; lastWrAddr[k] = regAddr[k];
      end
      if (rdReq[k]) rdCnt[k]++;
      if (cSet[k]) setCnt[k]++;
      if (cGet[k]) getCnt[k]++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit access; m=0 bus pins, m=1 three-wire pins
  task automatic access(input int m, input bit isRead, input bit b, output bit got);
    @(negedge clk);
    selN[m] = 1'b0;
    sdIn[m] = b;
    if (m == 0) begin
      if (isRead) rdN[0] = 1'b0; else wrN[0] = 1'b0;
    end else begin
      rdN[1] = isRead;
      @(negedge clk);
      wrN[1] = 1'b0;
    end
    repeat (6) @(negedge clk);
    got = sdOut[m];
    selN[m] = 1'b1; rdN[m] = 1'b1; wrN[m] = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wbit(input int m, input bit b);
    bit dummy;
    access(m, 1'b0, b, dummy);
  endtask

  task automatic rbit(input int m, output bit b);
    access(m, 1'b1, 1'b0, b);
  endtask

  task automatic sendAddr(input int m, input logic [3:0] a);
    for (int i = 0; i < 4; i++) wbit(m, a[i]);
  endtask

  task automatic writeCycle(input int m, input logic [3:0] a, input logic [7:0] v);
    sendAddr(m, a);
    for (int i = 0; i < 8; i++) wbit(m, v[i]);
  endtask

  task automatic readCycle(input int m, input logic [3:0] a, output logic [7:0] v);
    sendAddr(m, a);
    for (int i = 0; i < 8; i++) begin
      bit b;
      rbit(m, b);
      v[i] = b;
    end
  endtask

  task automatic reads(input int m, input int n);
    for (int i = 0; i < n; i++) begin
      bit b;
      rbit(m, b);
    end
  endtask

  task automatic runMode(input int m);
    logic [7:0] v;
    int w0, r0, s0, g0;
    string tag;
    tag = (m == 1) ? "R10" : "bus";

    // R1 R5: read sweep over every data address
    for (int a = 0; a < 14; a++) begin
      r0 = rdCnt[m];
      readCycle(m, 4'(a), v);
      check(v == pat(4'(a)), $sformatf("R5 %s read byte a=%0d", tag, a), v, pat(4'(a)));
      check(rdCnt[m] == r0 + 1, $sformatf("R5 %s single fetch", tag), rdCnt[m], r0 + 1);
      check(regAddr[m] == 4'(a), $sformatf("R1 %s address", tag), regAddr[m], a);
    end

    // R4 R6: back-to-back write sweep
    for (int a = 0; a < 14; a++) begin
      w0 = wrCnt[m];
      writeCycle(m, 4'(a), 8'(a * 19 + 7));
      check(wrCnt[m] == w0 + 1, $sformatf("R4 %s one strobe", tag), wrCnt[m], w0 + 1);
      check(lastWr[m] == 8'(a * 19 + 7), $sformatf("R4 %s data", tag), lastWr[m], 8'(a * 19 + 7));
      check(lastWrAddr[m] == 4'(a), $sformatf("R6 %s next cycle address", tag), lastWrAddr[m], a);
    end

    // R4: no strobe before the eighth bit
    w0 = wrCnt[m];
    sendAddr(m, 4'd6);
    for (int i = 0; i < 7; i++) wbit(m, 1'b1);
    check(wrCnt[m] == w0, $sformatf("R4 %s early strobe", tag), wrCnt[m], w0);
    wbit(m, 1'b0);
    check(lastWr[m] == 8'h7F && wrCnt[m] == w0 + 1, $sformatf("R4 %s late byte", tag), lastWr[m], 8'h7F);

    // R3: commands then a normal cycle
    s0 = setCnt[m]; g0 = getCnt[m]; r0 = rdCnt[m]; w0 = wrCnt[m];
    sendAddr(m, 4'hE);
    check(setCnt[m] == s0 + 1, $sformatf("R3 %s set pulse", tag), setCnt[m], s0 + 1);
    writeCycle(m, 4'd3, 8'h5A);
    check(lastWrAddr[m] == 4'd3 && lastWr[m] == 8'h5A, $sformatf("R3 %s after set", tag), lastWr[m], 8'h5A);
    sendAddr(m, 4'hF);
    check(getCnt[m] == g0 + 1, $sformatf("R3 %s get pulse", tag), getCnt[m], g0 + 1);
    check(rdCnt[m] == r0 + 1, $sformatf("R3 %s no fetch on command", tag), rdCnt[m], r0 + 1);
    writeCycle(m, 4'd12, 8'hC3);
    check(lastWrAddr[m] == 4'd12 && wrCnt[m] == w0 + 2, $sformatf("R3 %s after get", tag), lastWrAddr[m], 12);

    // R2: idle reads ignored, partial address discarded
    r0 = rdCnt[m];
    reads(m, 3);
    check(rdCnt[m] == r0, $sformatf("R2 %s idle reads", tag), rdCnt[m], r0);
    wbit(m, 1'b1); wbit(m, 1'b1);
    reads(m, 1);
    writeCycle(m, 4'd6, 8'h3C);
    check(lastWrAddr[m] == 4'd6 && lastWr[m] == 8'h3C, $sformatf("R2 %s partial dropped", tag), lastWrAddr[m], 6);

    // R7: resync from partial write data
    w0 = wrCnt[m];
    sendAddr(m, 4'd5);
    for (int i = 0; i < 3; i++) wbit(m, 1'b1);
    reads(m, 8);
    writeCycle(m, 4'd9, 8'h81);
    check(wrCnt[m] == w0 + 1 && lastWrAddr[m] == 4'd9, $sformatf("R7 %s from write", tag), lastWrAddr[m], 9);
    // R7: resync from partial read data
    sendAddr(m, 4'd2);
    reads(m, 5);
    reads(m, 8);
    writeCycle(m, 4'd10, 8'h42);
    check(lastWrAddr[m] == 4'd10 && lastWr[m] == 8'h42, $sformatf("R7 %s from read", tag), lastWr[m], 8'h42);
    // R7: resync from partial address
    wbit(m, 1'b0); wbit(m, 1'b1); wbit(m, 1'b1);
    reads(m, 8);
    writeCycle(m, 4'd1, 8'h99);
    check(lastWrAddr[m] == 4'd1, $sformatf("R7 %s from address", tag), lastWrAddr[m], 1);

    // R8: direction change during write and during read
    w0 = wrCnt[m];
    sendAddr(m, 4'd4);
    for (int i = 0; i < 3; i++) wbit(m, 1'b0);
    reads(m, 1);
    writeCycle(m, 4'd2, 8'hE7);
    check(wrCnt[m] == w0 + 1 && lastWrAddr[m] == 4'd2, $sformatf("R8 %s write dropped", tag), wrCnt[m], w0 + 1);
    sendAddr(m, 4'd8);
    reads(m, 2);
    wbit(m, 1'b1);
    writeCycle(m, 4'd11, 8'h18);
    check(wrCnt[m] == w0 + 2 && lastWrAddr[m] == 4'd11 && lastWr[m] == 8'h18,
          $sformatf("R8 %s read dropped", tag), lastWrAddr[m], 11);

    // R9: long gap inside a data cycle
    w0 = wrCnt[m];
    sendAddr(m, 4'd7);
    for (int i = 0; i < 4; i++) wbit(m, 1'b1);
    repeat (5000) @(negedge clk);
    for (int i = 0; i < 4; i++) wbit(m, 1'b0);
    check(wrCnt[m] == w0 + 1 && lastWr[m] == 8'h0F && lastWrAddr[m] == 4'd7,
          $sformatf("R9 %s gap", tag), lastWr[m], 8'h0F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    for (int k = 0; k < 2; k++) begin
      check({wrEn[k], rdReq[k], cSet[k], cGet[k], sdOut[k]} == 5'b0, "R11 pulses idle",
            {wrEn[k], rdReq[k], cSet[k], cGet[k], sdOut[k]}, 0);
      check(regAddr[k] == 4'd0, "R11 address zero", regAddr[k], 0);
    end
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    runMode(0);
    runMode(1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule